// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the memory side of a two-wire serial bus. It watches the clock line and the open-drain data line, recognises start and stop conditions, and answers a master that addresses it by its fixed family code plus three strap pins. A write transaction carries a two-byte memory address and one or more data bytes. A read transaction returns bytes from an internal byte array, either from the address held by an internal counter or from one the master has just set with an address-only write. The data line is modelled as a sampled input plus one output that, when high, pulls the line low.

Written bytes first collect in a one-page staging buffer. The stop that ends the transaction starts a timed write cycle. For its whole length the block ignores its own address, so a master can poll until the address word is acknowledged again. When the count expires, the staged bytes are copied into the array one per clock.

Top module: `twi_eeprom_slave`

## Requirements
- R1: After reset the block does not drive the data line. A start condition (data falling while clock is high) restarts address-word reception at any point, even in the middle of a byte. A stop condition (data rising while clock is high) returns the block to idle.
- R2: The first byte after a start is matched as follows: bits 7..4 must equal 4'b1010, bits 3..1 must equal `strap_i`, and bit 0 selects read (1) or write (0). On a mismatch the block gives no acknowledge and leaves the line alone until the next start.
- R3: Bits are sampled on the rising clock edge. The block changes its data-line drive only while the clock is low, except when releasing at a start or stop. An acknowledge holds the line low for the whole ninth clock.
- R4: A write (device byte, address high byte, address low byte, data byte, stop) stores the data byte at that address once the write cycle ends.
- R5: Further data bytes in the same write go to successive addresses. The address increment wraps inside the 64-byte page, so address bits 5..0 roll over and the higher bits stay fixed.
- R6: From the stop that launches a write until the cycle ends (WR_CYCLES clocks plus 64 commit clocks), the address word gets no acknowledge. After that it is acknowledged again.
- R7: A write that stops before one full data byte has been received leaves memory unchanged and starts no write cycle.
- R8: A read with no preceding address returns the byte at the internal counter. The counter holds the last accessed address plus one.
- R9: An address-only write followed by a repeated start and a read device byte returns the byte at the address just sent.
- R10: In a read, a master acknowledge (line low in the ninth clock) makes the block send the byte at the next address. A master no-acknowledge makes it release the line and wait for a start or stop.
- R11: Address bits above the array width are ignored. A sequential read past the last location continues at location 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level, as seen on the wire |
| strap_i | input | 3 | Device select straps compared with bits 3..1 of the device byte |
| sda_oe_o | output | 1 | When high, the pad pulls the data line low |

## Verification
On every cycle, the assertions check four things: the data-line drive moves only while the clock is low or when released at a bus condition; the idle state never drives the line; the staging buffer takes no byte while a write cycle runs; and a stop that ends a write holding data always raises busy, which in turn ends with the buffer empty. Only the bench scenarios can show the memory-level results. These are the stored values after single and page writes, the page wrap, the busy window seen through address polling, a partial byte that must not be written, the counter after a sequential read, and the roll-over past the top of the array.

// File: rtl/twi_eeprom_pkg.sv
package twi_eeprom_pkg;

  localparam logic [3:0] DEV_CODE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_WDATA,
    ST_RDATA
  } proto_st_t;

  typedef enum logic [1:0] {
    WC_IDLE,
    WC_WAIT,
    WC_COMMIT
  } wcyc_st_t;

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic rise_o,
  output logic fall_o,
  output logic start_o,
  output logic stop_o
);

  logic [SYNC-1:0] scl_sr, sda_sr;
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sr <= '1;
      sda_sr <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sr <= {scl_sr[SYNC-2:0], scl_i};
      sda_sr <= {sda_sr[SYNC-2:0], sda_i};
      scl_p  <= scl_sr[SYNC-1];
      sda_p  <= sda_sr[SYNC-1];
    end
  end

  assign scl_o   = scl_sr[SYNC-1];
  assign sda_o   = sda_sr[SYNC-1];
  assign rise_o  = scl_o & ~scl_p;
  assign fall_o  = ~scl_o & scl_p;
  assign start_o = scl_o & scl_p & sda_p & ~sda_o;
  assign stop_o  = scl_o & scl_p & ~sda_p & sda_o;

endmodule

// File: rtl/twi_mem_array.sv
module twi_mem_array #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);

  localparam int DEPTH = 1 << AW;

  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) cells[waddr_i] <= wdata_i;
  end

  assign rdata_o = cells[raddr_i];

endmodule

// File: rtl/twi_page_stage.sv
module twi_page_stage
  import twi_eeprom_pkg::*;
#(
  parameter int AW        = 11,
  parameter int PW        = 6,
  parameter int WR_CYCLES = 300
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic [AW-1:0] base_i,
  input  logic          wr_i,
  input  logic [PW-1:0] off_i,
  input  logic [7:0]    data_i,
  input  logic          go_i,
  output logic          busy_o,
  output logic          has_data_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [7:0]    mem_data_o
);

  localparam int PAGE = 1 << PW;
  localparam int TW   = $clog2(WR_CYCLES + 1);

  wcyc_st_t          ph_q, ph_d;
  logic [TW-1:0]     tmr_q, tmr_d;
  logic [PW-1:0]     idx_q, idx_d;
  logic [PAGE-1:0]   vld_q, vld_d;
  logic [AW-PW-1:0]  base_q, base_d;
  logic [7:0]        dat_q [PAGE];

  always_comb begin
    ph_d   = ph_q;
    tmr_d  = tmr_q;
    idx_d  = idx_q;
    vld_d  = vld_q;
    base_d = base_q;
    unique case (ph_q)
      WC_IDLE: begin
        if (clr_i) begin
          vld_d  = '0;
          base_d = base_i[AW-1:PW];
        end else if (wr_i) begin
          vld_d[off_i] = 1'b1;
        end else if (go_i && (vld_q != '0)) begin
          ph_d  = WC_WAIT;
          tmr_d = '0;
        end
      end
      WC_WAIT: begin
        tmr_d = tmr_q + 1'b1;
        if (tmr_q == TW'(WR_CYCLES - 1)) begin
          ph_d  = WC_COMMIT;
          idx_d = '0;
        end
      end
      WC_COMMIT: begin
        idx_d = idx_q + 1'b1;
        if (idx_q == PW'(PAGE - 1)) begin
          ph_d  = WC_IDLE;
          vld_d = '0;
        end
      end
      default: ph_d = WC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= WC_IDLE;
      tmr_q  <= '0;
      idx_q  <= '0;
      vld_q  <= '0;
      base_q <= '0;
    end else begin
      ph_q   <= ph_d;
      tmr_q  <= tmr_d;
      idx_q  <= idx_d;
      vld_q  <= vld_d;
      base_q <= base_d;
    end
  end

  // staging storage: data only, validity tracked by vld_q
  always_ff @(posedge clk) begin
    if (ph_q == WC_IDLE && !clr_i && wr_i) dat_q[off_i] <= data_i;
  end

  assign busy_o     = (ph_q != WC_IDLE);
  assign has_data_o = (vld_q != '0);
  assign mem_we_o   = (ph_q == WC_COMMIT) && vld_q[idx_q];
  assign mem_addr_o = {base_q, idx_q};
  assign mem_data_o = dat_q[idx_q];

  // R4
  commit_drains_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(busy_o) |-> !has_data_o);

endmodule

// File: rtl/twi_eeprom_slave.sv
module twi_eeprom_slave
  import twi_eeprom_pkg::*;
#(
  parameter int AW        = 11,
  parameter int PW        = 6,
  parameter int WR_CYCLES = 300,
  parameter int SYNC      = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  output logic       sda_oe_o
);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sy;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sy <= '0;
    else        rst_sy <= {rst_sy[0], 1'b1};
  end
  assign rst_ni = rst_sy[1];

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  twi_line_sync #(.SYNC(SYNC)) u_sync (
    .clk     (clk),
    .rst_ni  (rst_ni),
    .scl_i   (scl_i),
    .sda_i   (sda_i),
    .scl_o   (scl_s),
    .sda_o   (sda_s),
    .rise_o  (scl_rise),
    .fall_o  (scl_fall),
    .start_o (start_det),
    .stop_o  (stop_det)
  );

  proto_st_t     st_q, st_d;
  logic [3:0]    cnt_q, cnt_d;
  logic [7:0]    sh_q, sh_d;
  logic [7:0]    tx_q, tx_d;
  logic [7:0]    ahi_q, ahi_d;
  logic [AW-1:0] addr_q, addr_d;
  logic          sda_low_q, sda_low_d;
  logic          in_ack_q, in_ack_d;
  logic          mack_q, mack_d;

  logic          buf_clr, buf_wr, buf_go, wr_busy, has_data;
  logic          mem_we;
  logic [AW-1:0] mem_waddr, new_addr;
  logic [7:0]    mem_wdata, rd_data;
  logic          dev_hit;

  assign dev_hit  = (sh_q[7:4] == DEV_CODE) && (sh_q[3:1] == strap_i);
  assign new_addr = AW'({ahi_q, sh_q});

  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    sh_d      = sh_q;
    tx_d      = tx_q;
    ahi_d     = ahi_q;
    addr_d    = addr_q;
    sda_low_d = sda_low_q;
    in_ack_d  = in_ack_q;
    mack_d    = mack_q;
    buf_clr   = 1'b0;
    buf_wr    = 1'b0;
    buf_go    = 1'b0;
    if (start_det) begin
      st_d      = ST_DEV;
      cnt_d     = '0;
      in_ack_d  = 1'b0;
      sda_low_d = 1'b0;
      buf_clr   = 1'b1;
    end else if (stop_det) begin
      st_d      = ST_IDLE;
      cnt_d     = '0;
      in_ack_d  = 1'b0;
      sda_low_d = 1'b0;
      buf_go    = (st_q == ST_WDATA) && has_data;
    end else if (st_q != ST_IDLE) begin
      if (scl_rise) begin
        if (cnt_q == 4'd8) begin
          cnt_d  = '0;
          mack_d = ~sda_s;            // wired line: own ack reads as continue
        end else begin
          sh_d  = {sh_q[6:0], sda_s};
          cnt_d = cnt_q + 4'd1;
        end
      end else if (scl_fall) begin
        if (cnt_q == 4'd8 && !in_ack_q) begin
          in_ack_d = 1'b1;
          unique case (st_q)
            ST_DEV: begin
              if (dev_hit && !wr_busy) begin
                sda_low_d = 1'b1;
                st_d      = sh_q[0] ? ST_RDATA : ST_AHI;
              end else begin
                st_d     = ST_IDLE;
                in_ack_d = 1'b0;
              end
            end
            ST_AHI: begin
              sda_low_d = 1'b1;
              ahi_d     = sh_q;
              st_d      = ST_ALO;
            end
            ST_ALO: begin
              sda_low_d = 1'b1;
              addr_d    = new_addr;
              buf_clr   = 1'b1;
              st_d      = ST_WDATA;
            end
            ST_WDATA: begin
              sda_low_d = 1'b1;
              buf_wr    = 1'b1;
              addr_d    = {addr_q[AW-1:PW], addr_q[PW-1:0] + 1'b1};
            end
            default: sda_low_d = 1'b0;   // ST_RDATA: hand the line to the master
          endcase
        end else if (in_ack_q) begin
          in_ack_d  = 1'b0;
          sda_low_d = 1'b0;
          if (st_q == ST_RDATA) begin
            if (mack_q) begin
              tx_d      = rd_data;
              sda_low_d = ~rd_data[7];
              addr_d    = addr_q + 1'b1;
            end else begin
              st_d = ST_IDLE;
            end
          end
        end else if (st_q == ST_RDATA && cnt_q != 4'd0) begin
          tx_d      = {tx_q[6:0], 1'b0};
          sda_low_d = ~tx_q[6];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      cnt_q     <= '0;
      sh_q      <= '0;
      tx_q      <= '0;
      ahi_q     <= '0;
      addr_q    <= '0;
      sda_low_q <= 1'b0;
      in_ack_q  <= 1'b0;
      mack_q    <= 1'b0;
    end else begin
      st_q      <= st_d;
      cnt_q     <= cnt_d;
      sh_q      <= sh_d;
      tx_q      <= tx_d;
      ahi_q     <= ahi_d;
      addr_q    <= addr_d;
      sda_low_q <= sda_low_d;
      in_ack_q  <= in_ack_d;
      mack_q    <= mack_d;
    end
  end

  assign sda_oe_o = sda_low_q;

  twi_page_stage #(.AW(AW), .PW(PW), .WR_CYCLES(WR_CYCLES)) u_stage (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .clr_i      (buf_clr),
    .base_i     (new_addr),
    .wr_i       (buf_wr),
    .off_i      (addr_q[PW-1:0]),
    .data_i     (sh_q),
    .go_i       (buf_go),
    .busy_o     (wr_busy),
    .has_data_o (has_data),
    .mem_we_o   (mem_we),
    .mem_addr_o (mem_waddr),
    .mem_data_o (mem_wdata)
  );

  twi_mem_array #(.AW(AW)) u_mem (
    .clk     (clk),
    .we_i    (mem_we),
    .waddr_i (mem_waddr),
    .wdata_i (mem_wdata),
    .raddr_i (addr_q),
    .rdata_o (rd_data)
  );

  // R3
  drive_moves_low_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !$stable(sda_low_q) |-> (!scl_s || $past(start_det || stop_det)));

  // R2
  idle_silent_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (st_q == ST_IDLE) |-> !sda_low_q);

  // R6
  no_stage_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    buf_wr |-> !wr_busy);

  // R4
  stop_launches_cycle_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (stop_det && st_q == ST_WDATA && has_data && !wr_busy) |=> wr_busy);

endmodule

// File: tb/tb_twi_eeprom_slave.sv
module tb_twi_eeprom_slave;

  localparam int HP  = 10;
  localparam int AW  = 11;
  localparam int WRC = 300;
  localparam logic [7:0] DW = 8'hAA;   // 1010 101 0
  localparam logic [7:0] DR = 8'hAB;   // 1010 101 1

  typedef logic [7:0] bytes_t [8];
  typedef struct packed {
    logic [15:0] wa;
    logic [7:0]  wd;
    logic [15:0] ra;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{wa: 16'h0000, wd: 8'h3C, ra: 16'h0000},
    '{wa: 16'h07FF, wd: 8'hA5, ra: 16'h07FF},
    '{wa: 16'h0080, wd: 8'h5A, ra: 16'h0080},
    '{wa: 16'h0123, wd: 8'hC3, ra: 16'h0123},
    '{wa: 16'hF456, wd: 8'h96, ra: 16'h0456},
    '{wa: 16'h0200, wd: 8'h01, ra: 16'h0200}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic sda_line;
  int   n_run = 0;
  int   n_fail = 0;
  bit   done = 1'b0;
  bit   ack_held = 1'b1;

  always #5 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  twi_eeprom_slave #(.AW(AW), .PW(6), .WR_CYCLES(WRC), .SYNC(2)) dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_m),
    .sda_i    (sda_line),
    .strap_i  (3'b101),
    .sda_oe_o (sda_oe)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    scl_m = 1'b0; tick(HP);
    sda_m = 1'b1; tick(HP);
    scl_m = 1'b1; tick(HP);
    sda_m = 1'b0; tick(HP);
    scl_m = 1'b0; tick(2);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(HP);
    scl_m = 1'b1; tick(HP);
    sda_m = 1'b1; tick(HP);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; tick(HP);
      scl_m = 1'b1; tick(HP);
      scl_m = 1'b0; tick(2);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    logic e1, e2;
    send_bits(b, 8);
    sda_m = 1'b1; tick(HP);
    scl_m = 1'b1; tick(2);
    e1 = sda_oe; tick(3);
    ack = ~sda_line; tick(3);
    e2 = sda_oe; tick(HP - 8);
    scl_m = 1'b0; tick(2);
    if (e1 !== e2) ack_held = 1'b0;
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit give_ack);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(HP);
      scl_m = 1'b1; tick(HP / 2);
      b[i] = sda_line; tick(HP / 2);
      scl_m = 1'b0; tick(2);
    end
    sda_m = give_ack ? 1'b0 : 1'b1; tick(HP);
    scl_m = 1'b1; tick(HP);
    scl_m = 1'b0; tick(2);
    sda_m = 1'b1;
  endtask

  task automatic addr_phase(input logic [15:0] a, output bit ok);
    bit a0, a1, a2;
    bus_start();
    send_byte(DW, a0);
    send_byte(a[15:8], a1);
    send_byte(a[7:0], a2);
    ok = a0 & a1 & a2;
  endtask

  task automatic write_seq(input logic [15:0] a, input bytes_t d, input int n, output bit ok);
    bit ak;
    addr_phase(a, ok);
    for (int k = 0; k < n; k++) begin
      send_byte(d[k], ak);
      ok = ok & ak;
    end
    bus_stop();
  endtask

  task automatic wait_ready(output int polls, output bit got);
    bit ak;
    polls = 0;
    got = 1'b0;
    while (!got && polls < 50) begin
      bus_start();
      send_byte(DW, ak);
      bus_stop();
      if (ak) got = 1'b1;
      else polls++;
    end
  endtask

  task automatic read_seq(input logic [15:0] a, input int n, output bytes_t d);
    bit ok, ak;
    addr_phase(a, ok);
    bus_start();
    send_byte(DR, ak);
    for (int k = 0; k < n; k++) recv_byte(d[k], k != n - 1);
    bus_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    bytes_t d, rd;
    bit ok, ak, got;
    int polls;
    logic [7:0] b;

    tick(5);
    rst_n = 1'b1;
    tick(5);
    check(sda_oe === 1'b0, "R1 reset line released", sda_oe, 0);

    // table: byte write, poll, random read back (R4, R9, R11, R6)
    for (int i = 0; i < 6; i++) begin
      d[0] = VECS[i].wd;
      write_seq(VECS[i].wa, d, 1, ok);
      check(ok, "R4 write acknowledged", ok, 1);
      wait_ready(polls, got);
      if (i == 0) check(polls > 0, "R6 nack while busy", polls, 1);
      check(got, "R6 ack after cycle", got, 1);
      read_seq(VECS[i].ra, 1, rd);
      check(rd[0] === VECS[i].wd, (i == 4) ? "R11 upper bits ignored" : "R9 random read",
            rd[0], VECS[i].wd);
    end
    check(ack_held, "R3 ack held over ninth clock", ack_held, 1);

    // R2: wrong family code, then a following byte is ignored
    bus_start();
    send_byte(8'hBA, ak);
    check(!ak, "R2 wrong code nack", ak, 0);
    send_byte(8'h00, ak);
    check(!ak, "R2 ignored until start", ak, 0);
    bus_stop();
    bus_start();
    send_byte(8'hA2, ak);
    check(!ak, "R2 wrong strap nack", ak, 0);
    bus_stop();

    // R10 / R8: page write then sequential and current-address reads
    for (int k = 0; k < 5; k++) d[k] = 8'hE0 + 8'(k);
    write_seq(16'h0040, d, 5, ok);
    wait_ready(polls, got);
    read_seq(16'h0040, 4, rd);
    for (int k = 0; k < 4; k++)
      check(rd[k] === 8'hE0 + 8'(k), "R10 sequential read", rd[k], 8'hE0 + k);
    bus_start();
    send_byte(DR, ak);
    recv_byte(b, 1'b0);
    bus_stop();
    check(b === 8'hE4, "R8 current address read", b, 8'hE4);

    // R5: page write wraps within the 64-byte page
    d[0] = 8'h11; d[1] = 8'h22; d[2] = 8'h33; d[3] = 8'h44;
    write_seq(16'h007E, d, 4, ok);
    wait_ready(polls, got);
    read_seq(16'h007E, 2, rd);
    check(rd[0] === 8'h11 && rd[1] === 8'h22, "R5 page top", {rd[0], rd[1]}, 16'h1122);
    read_seq(16'h0040, 2, rd);
    check(rd[0] === 8'h33 && rd[1] === 8'h44, "R5 wrapped to page start", {rd[0], rd[1]}, 16'h3344);
    read_seq(16'h0080, 1, rd);
    check(rd[0] === 8'h5A, "R5 next page untouched", rd[0], 8'h5A);

    // R7: partial data byte, then address-only write
    addr_phase(16'h0080, ok);
    send_bits(8'hF0, 4);
    bus_stop();
    bus_start();
    send_byte(DW, ak);
    bus_stop();
    check(ak, "R7 no write cycle after partial byte", ak, 1);
    read_seq(16'h0080, 1, rd);
    check(rd[0] === 8'h5A, "R7 memory unchanged", rd[0], 8'h5A);
    addr_phase(16'h0123, ok);
    bus_stop();
    bus_start();
    send_byte(DW, ak);
    bus_stop();
    check(ak, "R7 address-only write not busy", ak, 1);

    // R1: repeated start inside a byte restarts address reception
    addr_phase(16'h0123, ok);
    send_bits(8'hFF, 3);
    bus_start();
    send_byte(DR, ak);
    recv_byte(b, 1'b0);
    bus_stop();
    check(b === 8'hC3, "R1 restart mid-byte", b, 8'hC3);

    // R11: roll over past the last location
    read_seq(16'h07FF, 2, rd);
    check(rd[0] === 8'hA5 && rd[1] === 8'h3C, "R11 roll-over", {rd[0], rd[1]}, 16'hA53C);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule